// File: doc/BRIEF.md
# Fault and Pending Interrupt Status Unit

This block holds two 16-bit status words for a processor. The fault word records machine-error events: each implemented bit is set by a one-cycle hardware pulse and stays set until software clears it. The pending word records interrupt requests in the same sticky way. Software reaches both words through a small command port. The fault word accepts read, load and clear commands. The pending word accepts read, set and clear commands.

The OR of every fault bit forms a machine-error request. This request appears as bit 14 of the pending word and no command can mask it. Three fault bits stay outside software's reach: the two channel-parity faults and the parallel-transfer fault. Only hardware events set them and only reset clears them. The parallel-transfer fault has its own input, so several error checkers can share one OR-tied line.

Interrupt priority, vectoring, masks and the logic that detects the faults all live outside this block.

Top module: `fault_status_unit`

## Requirements
- R1: After a synchronous active-high reset, the fault word, the pending word, `mach_err` and `rd_valid` are all zero.
- R2: A one-cycle pulse on `flt_evt[i]`, for an implemented bit i (15 down to 4), sets fault bit i at the next clock edge. The bit then stays set until a clear command or reset removes it.
- R3: Fault bits 3 to 0 always read as zero, even when their event inputs are pulsed.
- R4: Command code 2 (fault load) replaces fault bits 15:13, 10 and 8:4 with `cmd_data`. Fault bits 12, 11 and 9 keep their values.
- R5: Command code 3 (fault clear) zeroes each fault bit among 15:13, 10 and 8:4 where `cmd_data` holds a one. Fault bits 12, 11 and 9 keep their values.
- R6: When a hardware set and a software clear or load target the same bit in the same cycle, the bit ends up set. This holds for both words.
- R7: `mach_err` and pending bit 14 are both high exactly when at least one fault bit is set. They fall in the cycle after the last fault bit clears.
- R8: Software set (code 5), software clear (code 6) and request input 14 have no effect on pending bit 14.
- R9: A pulse on `irq_req[i]`, for i other than 14, sets pending bit i, and the bit stays set. Command code 5 (pending set) sets each pending bit where `cmd_data` holds a one.
- R10: Command code 6 (pending clear) zeroes each pending bit, other than 14, where `cmd_data` holds a one.
- R11: Code 1 (fault read) or code 4 (pending read) makes `rd_valid` high one cycle later. In that cycle `rd_data` holds the word as it stood when the command was issued, and a pending read includes bit 14.
- R12: When `ptx_err_in` is high at a clock edge, fault bit 9 is set.
- R13: Code 0, code 7, and any command with `cmd_valid` low change neither word and do not raise `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (0 none, 1 fault read, 2 fault load, 3 fault clear, 4 pending read, 5 pending set, 6 pending clear, 7 reserved) |
| cmd_data | input | 16 | Load value or bit mask |
| flt_evt | input | 16 | Hardware fault event pulses, one per bit |
| ptx_err_in | input | 1 | Parallel-transfer error line, sets fault bit 9 |
| irq_req | input | 16 | Interrupt request pulses, one per bit |
| rd_data | output | 16 | Registered read result |
| rd_valid | output | 1 | Read result valid |
| fault_reg | output | 16 | Current fault word |
| pend_reg | output | 16 | Current pending word, bit 14 being the machine-error request |
| mach_err | output | 1 | Unmaskable machine-error request |

## Verification
The bench pulses every one of the sixteen fault and request inputs in turn. A design that wired events to the wrong bit, or let the unused low fault bits latch, would show a stray one in the word. It drives load and clear with all-ones and mixed patterns after the protected bits have been set by hardware. A design that left those bits writable would lose them. It issues a clear and an event to the same bit in one cycle, where a design that gave the clear priority would drop the event. It also clears fault bits one at a time while it watches the machine-error bit, which a latched version would hold high after the last fault is gone. Finally, it checks that software cannot force pending bit 14 up or down.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
    localparam int REG_W     = 16;
    localparam int OP_W      = 3;
    localparam int MERR_BIT  = 14;
    localparam int PTX_BIT   = 9;

    typedef logic [REG_W-1:0] word_t;

    // Bits that exist in the fault word
    localparam word_t IMPL_MASK  = 16'hFFF0;
    // Bits software may not touch (channel parity x2, parallel transfer)
    localparam word_t GUARD_MASK = 16'h1A00;
    localparam word_t SW_MASK    = IMPL_MASK & ~GUARD_MASK;
    localparam word_t PEND_KEEP  = ~(word_t'(1) << MERR_BIT);

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 3'd0,
        OP_FRD  = 3'd1,
        OP_FLD  = 3'd2,
        OP_FCLR = 3'd3,
        OP_PRD  = 3'd4,
        OP_PSET = 3'd5,
        OP_PCLR = 3'd6,
        OP_RSV  = 3'd7
    } op_e;

    typedef struct packed {
        logic  f_rd;
        logic  f_ld;
        logic  f_clr;
        logic  p_rd;
        logic  p_set;
        logic  p_clr;
        word_t data;
    } strobe_t;

    function automatic word_t sw_merge(word_t old_v, word_t new_v);
        return (old_v & ~SW_MASK) | (new_v & SW_MASK);
    endfunction
endpackage

// File: rtl/fsu_cmd_decode.sv
module fsu_cmd_decode
    import fsu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    input  logic [OP_W-1:0] cmd_op,
    input  word_t           cmd_data,
    output strobe_t         stb
);
    always_comb begin
        stb      = '0;
        stb.data = cmd_data;
        if (cmd_valid) begin
            case (op_e'(cmd_op))
                OP_FRD:  stb.f_rd  = 1'b1;
                OP_FLD:  stb.f_ld  = 1'b1;
                OP_FCLR: stb.f_clr = 1'b1;
                OP_PRD:  stb.p_rd  = 1'b1;
                OP_PSET: stb.p_set = 1'b1;
                OP_PCLR: stb.p_clr = 1'b1;
                default: ;
            endcase
        end
    end

    // R13
    single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({stb.f_rd, stb.f_ld, stb.f_clr, stb.p_rd, stb.p_set, stb.p_clr}));
endmodule

// File: rtl/fsu_fault_word.sv
module fsu_fault_word
    import fsu_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  strobe_t stb,
    input  word_t   evt,
    input  logic    ptx_err,
    output word_t   fault_q
);
    word_t base_v, hw_v, fault_d;

    always_comb begin
        base_v = fault_q;
        if (stb.f_ld)
            base_v = sw_merge(fault_q, stb.data);
        else if (stb.f_clr)
            base_v = fault_q & ~(stb.data & SW_MASK);
        hw_v    = evt | (word_t'(ptx_err) << PTX_BIT);
        fault_d = (base_v | hw_v) & IMPL_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) fault_q <= '0;
        else     fault_q <= fault_d;
    end

    // R3
    unused_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        fault_q[3:0] == 4'b0);
    // R2
    event_sets_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (|(evt & IMPL_MASK)) |=> ((fault_q & $past(evt & IMPL_MASK)) == $past(evt & IMPL_MASK)));
    // R4
    guarded_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((evt & GUARD_MASK) == '0 && !ptx_err) |=> ((fault_q & GUARD_MASK) == $past(fault_q & GUARD_MASK)));
endmodule

// File: rtl/fsu_pend_word.sv
module fsu_pend_word
    import fsu_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  strobe_t stb,
    input  word_t   req,
    input  logic    fault_any,
    output word_t   pend_q
);
    word_t pend_s, pend_d, clr_v, set_v;

    always_comb begin
        clr_v  = stb.p_clr ? stb.data : '0;
        set_v  = stb.p_set ? stb.data : '0;
        pend_d = ((pend_s & ~clr_v) | set_v | req) & PEND_KEEP;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_s <= '0;
        else     pend_s <= pend_d;
    end

    assign pend_q = pend_s | (word_t'(fault_any) << MERR_BIT);

    // R6
    req_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|(req & PEND_KEEP)) |=> ((pend_q & $past(req & PEND_KEEP)) == $past(req & PEND_KEEP)));
endmodule

// File: rtl/fault_status_unit.sv
module fault_status_unit
    import fsu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [2:0]  cmd_op,
    input  logic [15:0] cmd_data,
    input  logic [15:0] flt_evt,
    input  logic        ptx_err_in,
    input  logic [15:0] irq_req,
    output logic [15:0] rd_data,
    output logic        rd_valid,
    output logic [15:0] fault_reg,
    output logic [15:0] pend_reg,
    output logic        mach_err
);
    strobe_t stb;
    word_t   fault_w, pend_w;

    fsu_cmd_decode u_dec (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .stb(stb)
    );

    fsu_fault_word u_flt (
        .clk(clk), .rst(rst), .stb(stb), .evt(flt_evt),
        .ptx_err(ptx_err_in), .fault_q(fault_w)
    );

    fsu_pend_word u_pnd (
        .clk(clk), .rst(rst), .stb(stb), .req(irq_req),
        .fault_any(|fault_w), .pend_q(pend_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= stb.f_rd | stb.p_rd;
            rd_data  <= stb.f_rd ? fault_w : (stb.p_rd ? pend_w : '0);
        end
    end

    assign fault_reg = fault_w;
    assign pend_reg  = pend_w;
    assign mach_err  = pend_w[MERR_BIT];

    // R7
    merr_tracks_chk: assert property (@(posedge clk) disable iff (rst)
        (fault_reg != '0) |-> mach_err);
    // R11
    read_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_op == 3'd1 || cmd_op == 3'd4)) |=> rd_valid);
    // R13
    no_read_chk: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && (cmd_op == 3'd1 || cmd_op == 3'd4)) |=> !rd_valid);
endmodule

// File: tb/fault_status_unit_test.sv
module fault_status_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [15:0] cmd_data, flt_evt, irq_req;
    logic        ptx_err_in;
    logic [15:0] rd_data, fault_reg, pend_reg;
    logic        rd_valid, mach_err;

    int checks = 0;
    int fails  = 0;
    logic [15:0] mf, mp;

    always #5 clk = ~clk;

    fault_status_unit uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .flt_evt(flt_evt), .ptx_err_in(ptx_err_in),
        .irq_req(irq_req), .rd_data(rd_data), .rd_valid(rd_valid),
        .fault_reg(fault_reg), .pend_reg(pend_reg), .mach_err(mach_err)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] pend_view();
        return mp | ((mf != 16'h0) ? 16'h4000 : 16'h0);
    endfunction

    // One clock: drive at falling edge, sample 1 ns after rising edge
    task automatic step(string tag, logic v, logic [2:0] op, logic [15:0] d,
                        logic [15:0] fe, logic px, logic [15:0] ie);
        logic        exp_rv;
        logic [15:0] exp_rd;
        @(negedge clk);
        cmd_valid = v; cmd_op = op; cmd_data = d;
        flt_evt = fe; ptx_err_in = px; irq_req = ie;
        exp_rv = v && (op == 3'd1 || op == 3'd4);
        exp_rd = !exp_rv ? 16'h0 : (op == 3'd1 ? mf : pend_view());
        if (v && op == 3'd2) mf = (mf & ~16'hE5F0) | (d & 16'hE5F0);
        if (v && op == 3'd3) mf = mf & ~(d & 16'hE5F0);
        mf = (mf | fe | (px ? 16'h0200 : 16'h0)) & 16'hFFF0;
        if (v && op == 3'd6) mp = mp & ~d;
        if (v && op == 3'd5) mp = mp | d;
        mp = (mp | ie) & 16'hBFFF;
        @(posedge clk); #1;
        chk({tag, " fault"}, fault_reg, mf);
        chk({tag, " pend"}, pend_reg, pend_view());
        chk({tag, " merr"}, {15'b0, mach_err}, {15'b0, mf != 16'h0});
        chk({tag, " rdv"}, {15'b0, rd_valid}, {15'b0, exp_rv});
        if (exp_rv) chk({tag, " rdata"}, rd_data, exp_rd);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cmd_valid = 0; cmd_op = 0; cmd_data = 0;
        flt_evt = 0; ptx_err_in = 0; irq_req = 0;
        @(posedge clk); #1;
        @(negedge clk); rst = 1'b0;
        mf = 0; mp = 0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; cmd_valid = 0; cmd_op = 0; cmd_data = 0;
        flt_evt = 0; ptx_err_in = 0; irq_req = 0; mf = 0; mp = 0;
        repeat (2) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 fault", fault_reg, 16'h0);
        chk("R1 pend", pend_reg, 16'h0);
        chk("R1 rdv", {15'b0, rd_valid}, 16'h0);
        chk("R1 merr", {15'b0, mach_err}, 16'h0);
        @(negedge clk); rst = 1'b0;

        // R2 / R3: each event bit alone, then sticky hold
        for (int i = 0; i < 16; i++) begin
            step("R2 R3 evt", 0, 0, 0, 16'h1 << i, 0, 0);
            step("R2 hold", 0, 0, 0, 0, 0, 0);
            step("R11 fault rd", 1, 1, 0, 0, 0, 0);
            do_reset();
        end

        // R12 wired error input
        step("R12 ptx", 0, 0, 0, 0, 1, 0);
        step("R12 hold", 0, 0, 0, 0, 0, 0);

        // R4 load with guarded bits set by hardware
        step("R4 seed", 0, 0, 0, 16'h1800, 0, 0);
        foreach (cmd_data[k]) begin
            step("R4 load", 1, 2, 16'hFFFF ^ (16'h1 << k), 0, 0, 0);
        end
        step("R4 load zero", 1, 2, 16'h0000, 0, 0, 0);
        step("R4 load ones", 1, 2, 16'hFFFF, 0, 0, 0);

        // R5 clear one bit at a time, R7 falls only when empty
        for (int k = 15; k >= 0; k--) begin
            step("R5 R7 clr", 1, 3, 16'h1 << k, 0, 0, 0);
        end
        do_reset();
        step("R7 seed", 0, 0, 0, 16'h0090, 0, 0);
        step("R7 clr one", 1, 3, 16'h0080, 0, 0, 0);
        step("R7 clr last", 1, 3, 16'h0010, 0, 0, 0);

        // R6 set beats clear
        step("R6 fault", 1, 3, 16'hFFFF, 16'h8000, 0, 0);
        step("R6 fault ld", 1, 2, 16'h0000, 16'h0040, 0, 0);
        step("R6 pend seed", 1, 5, 16'h0003, 0, 0, 0);
        step("R6 pend", 1, 6, 16'h0003, 0, 0, 16'h0001);

        // R9 / R10 pending sweep
        do_reset();
        for (int i = 0; i < 16; i++) begin
            step("R9 req", 0, 0, 0, 0, 0, 16'h1 << i);
            step("R11 pend rd", 1, 4, 0, 0, 0, 0);
            step("R10 clr", 1, 6, 16'h1 << i, 0, 0, 0);
        end
        step("R9 set", 1, 5, 16'hA5A5, 0, 0, 0);
        step("R10 clr mix", 1, 6, 16'h0F0F, 0, 0, 0);

        // R8 bit 14 under software and request input
        step("R8 set", 1, 5, 16'h4000, 0, 0, 16'h4000);
        step("R8 seed fault", 0, 0, 0, 16'h0100, 0, 0);
        step("R8 clr", 1, 6, 16'hFFFF, 0, 0, 0);
        step("R11 pend rd merr", 1, 4, 0, 0, 0, 0);

        // R13 ignored commands
        step("R13 seed", 1, 5, 16'h00F0, 0, 0, 0);
        step("R13 op7", 1, 7, 16'hFFFF, 0, 0, 0);
        step("R13 op0", 1, 0, 16'hFFFF, 0, 0, 0);
        for (int op = 0; op < 8; op++) begin
            step("R13 invalid", 0, 3'(op), 16'hFFFF, 0, 0, 0);
        end

        finish_run();
    end
endmodule